// File: doc/BRIEF.md
# Banked 8K x 16 Memory with Decoded Bank Selects

This block gives a processor bus one 8K-word by 16-bit read/write space. The storage is sixteen 1K x 8 synchronous RAM banks. They are arranged as eight rows, and each row holds two byte lanes side by side. The upper three address bits go through a gated 3-to-8 decoder, which produces one active-low select per row. The lower ten address bits go to every bank.

Two active-low strobes are built from the bus clock phase and the read/write line. The read strobe is asserted only while the phase is high and the line reads. The write strobe is asserted only while the phase is high and the line writes. A bank acts only when its row select and one of the strobes are both low.

Read data is registered in the banks and combined onto one 16-bit bus. When no read took place, the bus returns zeros instead of floating.

Top module: `banked_mem_array`

## Requirements
- R1: Address bits [9:0] select the word inside a bank and bits [12:10] select the row. Two addresses with the same low bits in different rows hold independent words.
- R2: With `en` high, exactly one row select is low, the one whose index equals addr[12:10]. With `en` low, every row select is high.
- R3: The read strobe is low exactly when `phase` and `rd_wr` are both high. The write strobe is low exactly when `phase` is high and `rd_wr` is low. `rd_wr` = 1 means read and 0 means write.
- R4: On a rising clock edge with `en`=1, `phase`=1 and `rd_wr`=0, the full 16-bit `wdata` is stored at `addr`. Bits [15:8] go to the upper-lane bank and bits [7:0] go to the lower-lane bank.
- R5: An access with `en`=0, or with `phase`=0, changes no stored word.
- R6: After a rising edge with `en`=1, `phase`=1 and `rd_wr`=1, `rdata` holds the word stored at `addr` until the next rising edge.
- R7: After any rising edge that is not a read access, `rdata` is all zeros.
- R8: While `rst_n` is low, and after reset until the first read access, `rdata` is zero.
- R9: A write alters only the selected row. Banks in every other row keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all banks |
| rst_n | input | 1 | Asynchronous active-low reset of the read registers |
| addr | input | 13 | Word address: [12:10] row, [9:0] word within bank |
| phase | input | 1 | Bus clock phase; strobes are only asserted while it is high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| wdata | input | 16 | Write data |
| en | input | 1 | Subsystem enable; the active-high decoder enable |
| rdata | output | 16 | Registered read data, zero when no read took place |

## Verification
The following are checked on every cycle:
- The row selects stay one-hot-or-none.
- The selected row follows the upper address bits.
- Every select is released when `en` is low.
- Each strobe tracks its phase and read/write qualification.
- `rdata` returns to zero after every non-read edge.

Only the bench's scenarios can show the rest:
- Stored words survive writes that were blocked by a low enable or a low phase.
- Byte lanes land in the right half of the word.
- Words with equal low address bits in different rows stay separate.

// File: rtl/banked_mem_pkg.sv
package banked_mem_pkg;
    parameter int BANK_AW   = 10;
    parameter int BANK_DW   = 8;
    parameter int ROW_BITS  = 3;
    parameter int LANES     = 2;
    localparam int ROWS     = 1 << ROW_BITS;
    localparam int ADDR_W   = BANK_AW + ROW_BITS;
    localparam int DATA_W   = BANK_DW * LANES;
    localparam int BANK_DEPTH = 1 << BANK_AW;
endpackage

// File: rtl/bank_row_decoder.sv
module bank_row_decoder #(
    parameter int SEL_W = 3,
    localparam int OUT_N = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             g1,
    input  logic             g2a_n,
    input  logic             g2b_n,
    output logic [OUT_N-1:0] y_n
);
    logic gate_on;

    assign gate_on = g1 & ~g2a_n & ~g2b_n;

    always_comb begin
        y_n = '1;
        for (int i = 0; i < OUT_N; i++) begin
            if (gate_on && (sel == SEL_W'(i))) begin
                y_n[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen (
    input  logic phase,
    input  logic rd_wr,
    output logic oe_n,
    output logic we_n
);
    assign oe_n = ~(phase & rd_wr);
    assign we_n = ~(phase & ~rd_wr);
endmodule

// File: rtl/sync_ram_bank.sv
module sync_ram_bank #(
    parameter int AW = 10,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a,
    input  logic          cs_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!cs_n && !we_n) begin
            cells[a] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (!cs_n && !oe_n) begin
            dout <= cells[a];
        end else begin
            dout <= '0;
        end
    end
endmodule

// File: rtl/banked_mem_array.sv
module banked_mem_array
    import banked_mem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              phase,
    input  logic              rd_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              en,
    output logic [DATA_W-1:0] rdata
);
    logic [ROWS-1:0]    cs_n;
    logic               oe_n;
    logic               we_n;
    logic [BANK_DW-1:0] bank_q [ROWS][LANES];

    bank_row_decoder #(.SEL_W(ROW_BITS)) u_dec (
        .sel   (addr[ADDR_W-1:BANK_AW]),
        .g1    (en),
        .g2a_n (1'b0),
        .g2b_n (1'b0),
        .y_n   (cs_n)
    );

    bus_strobe_gen u_strb (
        .phase (phase),
        .rd_wr (rd_wr),
        .oe_n  (oe_n),
        .we_n  (we_n)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            sync_ram_bank #(.AW(BANK_AW), .DW(BANK_DW)) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .a     (addr[BANK_AW-1:0]),
                .cs_n  (cs_n[r]),
                .oe_n  (oe_n),
                .we_n  (we_n),
                .din   (wdata[l*BANK_DW +: BANK_DW]),
                .dout  (bank_q[r][l])
            );
        end
    end

    // Unselected banks return zero, so OR-ing the rows forms the bus.
    always_comb begin
        rdata = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int l = 0; l < LANES; l++) begin
                rdata[l*BANK_DW +: BANK_DW] = rdata[l*BANK_DW +: BANK_DW] | bank_q[r][l];
            end
        end
    end
endmodule

// File: rtl/banked_mem_checker.sv
module banked_mem_checker
    import banked_mem_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              phase,
    input logic              rd_wr,
    input logic              en,
    input logic [ROWS-1:0]   cs_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [DATA_W-1:0] rdata
);
    a_r2_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    a_r2_cs_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (cs_n == '1));

    a_r2_cs_index: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cs_n[addr[ADDR_W-1:BANK_AW]] == 1'b0));

    a_r3_oe_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && rd_wr) |-> !oe_n);

    a_r3_we_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && !rd_wr) |-> !we_n);

    a_r3_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |-> (oe_n && we_n));

    a_r7_zero_after_nonread: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && phase && rd_wr) |=> (rdata == '0));
endmodule

bind banked_mem_array banked_mem_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .phase (phase),
    .rd_wr (rd_wr),
    .en    (en),
    .cs_n  (cs_n),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .rdata (rdata)
);

// File: tb/banked_mem_array_test.sv
module banked_mem_array_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic        phase = 1'b0;
    logic        rd_wr = 1'b1;
    logic [15:0] wdata = '0;
    logic        en = 1'b0;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;

    localparam logic [28:0] VEC [0:15] = '{
        {13'h0005, 16'h1E01}, {13'h03FF, 16'h2D12},
        {13'h0405, 16'h3C23}, {13'h07FF, 16'h4B34},
        {13'h0805, 16'h5A45}, {13'h0BFF, 16'h6956},
        {13'h0C05, 16'h7867}, {13'h0FFF, 16'h8778},
        {13'h1005, 16'h9689}, {13'h13FF, 16'hA59A},
        {13'h1405, 16'hB4AB}, {13'h17FF, 16'hC3BC},
        {13'h1805, 16'hD2CD}, {13'h1BFF, 16'hE1DE},
        {13'h1C05, 16'hF0EF}, {13'h1FFF, 16'h0FF0}
    };

    banked_mem_array uut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .phase (phase),
        .rd_wr (rd_wr),
        .wdata (wdata),
        .en    (en),
        .rdata (rdata)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rdata=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let the rising edge act, sample 1 ns later.
    task automatic cyc(input logic e, input logic ph, input logic rw,
                       input logic [12:0] a, input logic [15:0] d);
        @(negedge clk);
        en = e; phase = ph; rd_wr = rw; addr = a; wdata = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: rdata=%h expected=completion", rdata);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R8: zero during reset, even with a read presented
        en = 1'b1; phase = 1'b1; rd_wr = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R8 in reset", rdata, 16'h0000);
        cyc(1'b0, 1'b0, 1'b1, '0, '0);
        rst_n = 1'b1;
        cyc(1'b1, 1'b0, 1'b1, '0, '0);
        check("R8 after reset", rdata, 16'h0000);

        // R4/R1: write the table across all rows and both lanes
        for (int i = 0; i < 16; i++) begin
            cyc(1'b1, 1'b1, 1'b0, VEC[i][28:16], VEC[i][15:0]);
            check("R7 after write", rdata, 16'h0000);
        end
        // R6/R1/R9: read every entry back
        for (int i = 0; i < 16; i++) begin
            cyc(1'b1, 1'b1, 1'b1, VEC[i][28:16], 16'hFFFF);
            check("R6 readback", rdata, VEC[i][15:0]);
        end

        // R7: an idle cycle after a read clears the bus
        cyc(1'b1, 1'b0, 1'b1, VEC[0][28:16], '0);
        check("R7 idle after read", rdata, 16'h0000);

        // R5: a write with phase low stores nothing
        cyc(1'b1, 1'b0, 1'b0, VEC[0][28:16], 16'hDEAD);
        check("R7 phase-low write", rdata, 16'h0000);
        cyc(1'b1, 1'b1, 1'b1, VEC[0][28:16], '0);
        check("R5 phase low", rdata, VEC[0][15:0]);

        // R5: a write with enable low stores nothing
        cyc(1'b0, 1'b1, 1'b0, VEC[3][28:16], 16'hBEEF);
        cyc(1'b1, 1'b1, 1'b1, VEC[3][28:16], '0);
        check("R5 enable low", rdata, VEC[3][15:0]);

        // R2: a read with enable low returns zero
        cyc(1'b0, 1'b1, 1'b1, VEC[5][28:16], '0);
        check("R2 enable low read", rdata, 16'h0000);
        // R3: a read with phase low returns zero
        cyc(1'b1, 1'b0, 1'b1, VEC[5][28:16], '0);
        check("R3 phase low read", rdata, 16'h0000);

        // R9/R1: overwrite row 2 word 0x005, other rows with the same low bits keep theirs
        cyc(1'b1, 1'b1, 1'b0, VEC[4][28:16], 16'h55AA);
        cyc(1'b1, 1'b1, 1'b1, VEC[4][28:16], '0);
        check("R4 overwrite", rdata, 16'h55AA);
        cyc(1'b1, 1'b1, 1'b1, VEC[2][28:16], '0);
        check("R9 row 1 untouched", rdata, VEC[2][15:0]);
        cyc(1'b1, 1'b1, 1'b1, VEC[6][28:16], '0);
        check("R9 row 3 untouched", rdata, VEC[6][15:0]);

        // R4: the lanes are independent halves of the word
        cyc(1'b1, 1'b1, 1'b0, VEC[15][28:16], 16'hFF00);
        cyc(1'b1, 1'b1, 1'b1, VEC[15][28:16], '0);
        check("R4 upper lane", rdata, 16'hFF00);
        cyc(1'b1, 1'b1, 1'b0, VEC[15][28:16], 16'h00FF);
        cyc(1'b1, 1'b1, 1'b1, VEC[15][28:16], '0);
        check("R4 lower lane", rdata, 16'h00FF);

        // R6: the read data holds for exactly the cycle after the read
        cyc(1'b1, 1'b1, 1'b1, VEC[9][28:16], '0);
        check("R6 hold", rdata, VEC[9][15:0]);
        cyc(1'b1, 1'b1, 1'b0, 13'h0200, 16'h1234);
        check("R7 write after read", rdata, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule